// File: doc/BRIEF.md
# Writeback Slot Allocator

This block sits between the execution units and the commit stage. Finished instructions arrive on several request ports. Each is placed into a writeback buffer that holds WIDTH slots for each of DEPTH future cycles. The buffer advances one row per clock, so the lowest row is always the group being handed to commit in the current cycle.

A request takes the first free slot. The search starts in the row that reaches the head on the next clock. It moves up through the slot indices of that row and then on to later rows. The search starts afresh every cycle. Requests on the same clock are served in port order, and each one sees the slots taken by lower-numbered ports.

For every instruction at the head, the block raises a wakeup strobe and scoreboard-set strobes for its destination registers. It does so only when the instruction is not squashed, has executed and carries no fault. All other instructions still go to commit, but without a wakeup.

Top module: `wb_slot_alloc`

## Requirements
- R1: While reset is held, and in the first cycle after it, the head is empty: `cmt_count` is 0 and every `cmt_valid` bit is 0.
- R2: A request accepted while the buffer is empty is at the head on the next cycle, in slot 0, with its tag.
- R3: When several requests arrive on the same clock, the lower-numbered port takes the lower slot, or the earlier row.
- R4: A request that finds its row full (WIDTH entries) is placed in the first later row that has room, and so reaches commit one cycle later for each row it was pushed up.
- R5: The buffer advances exactly one row per clock. An entry placed in row k (counting from 0) is at the head k+1 cycles after its request clock.
- R6: The head group is packed from slot 0: `cmt_valid[s]` is 1 exactly for s < `cmt_count`, and `cmt_count` never exceeds WIDTH.
- R7: Total capacity is WIDTH*DEPTH entries. A request that finds no free slot raises its `req_overflow` bit in the same cycle and is dropped; its tag never reaches the head.
- R8: `cmt_wake[s]` is 1 only for a valid head entry whose request had squashed=0, executed=1 and fault=0. `sb_set_valid[s*NDST+d]` equals `cmt_wake[s]` AND that request's destination-valid bit d, and `sb_set_reg` for that bit carries the register number d of that request.
- R9: An entry that is squashed, not executed or faulted still appears at the head with its tag and `cmt_valid` set, with its wakeup and scoreboard strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NREQ | One completion request per port |
| req_tag | input | NREQ*TAG_W | Instruction tag for each port |
| req_squashed | input | NREQ | The instruction was squashed |
| req_executed | input | NREQ | The instruction has executed |
| req_fault | input | NREQ | The instruction carries a fault |
| req_dst_valid | input | NREQ*NDST | Destination register used, per port and destination |
| req_dst | input | NREQ*NDST*REG_W | Destination register numbers |
| req_overflow | output | NREQ | Request found no free slot and was dropped |
| cmt_valid | output | WIDTH | Head slot holds an instruction for commit |
| cmt_tag | output | WIDTH*TAG_W | Tags of the head group |
| cmt_count | output | $clog2(WIDTH+1) | Number of entries in the head group |
| cmt_wake | output | WIDTH | Wakeup strobe for each head slot |
| sb_set_valid | output | WIDTH*NDST | Scoreboard set strobe per slot and destination |
| sb_set_reg | output | WIDTH*NDST*REG_W | Register to mark ready for each strobe |

## Verification
The bench drives three ports into a two-wide buffer. Because requests outnumber slots, the buffer fills over time. This checks that a full row spills into the next row instead of overwriting an entry, and that a request made when the buffer is full is flagged and dropped rather than taking a slot. Requests on the same clock check port priority: a design that searched from a stale cursor would hand the same slot to two ports. Squashed, unexecuted and faulted instructions are mixed in. A wakeup gate that tested only one of the three conditions would mark registers ready for instructions that produced nothing.

// File: rtl/wb_slot_alloc.sv
module wb_slot_alloc #(
  parameter int WIDTH = 2,
  parameter int DEPTH = 4,
  parameter int NREQ  = 3,
  parameter int TAG_W = 6,
  parameter int NDST  = 2,
  parameter int REG_W = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NREQ-1:0]             req_valid,
  input  logic [NREQ*TAG_W-1:0]       req_tag,
  input  logic [NREQ-1:0]             req_squashed,
  input  logic [NREQ-1:0]             req_executed,
  input  logic [NREQ-1:0]             req_fault,
  input  logic [NREQ*NDST-1:0]        req_dst_valid,
  input  logic [NREQ*NDST*REG_W-1:0]  req_dst,
  output logic [NREQ-1:0]             req_overflow,
  output logic [WIDTH-1:0]            cmt_valid,
  output logic [WIDTH*TAG_W-1:0]      cmt_tag,
  output logic [$clog2(WIDTH+1)-1:0]  cmt_count,
  output logic [WIDTH-1:0]            cmt_wake,
  output logic [WIDTH*NDST-1:0]       sb_set_valid,
  output logic [WIDTH*NDST*REG_W-1:0] sb_set_reg
);
  localparam int CNT_W = $clog2(WIDTH+1);
  localparam int ENT_W = TAG_W + 1 + NDST + NDST*REG_W;
  localparam int EL_B  = TAG_W;
  localparam int DV_B  = TAG_W + 1;
  localparam int DR_B  = TAG_W + 1 + NDST;

  logic [CNT_W-1:0] cnt_q [DEPTH];
  logic [CNT_W-1:0] cnt_d [DEPTH];
  logic [ENT_W-1:0] ent_q [DEPTH][WIDTH];
  logic [ENT_W-1:0] ent_d [DEPTH][WIDTH];

  always_comb begin
    for (int r = 0; r < DEPTH; r++) begin
      cnt_d[r] = (r < DEPTH-1) ? cnt_q[(r < DEPTH-1) ? r+1 : r] : '0;
      for (int s = 0; s < WIDTH; s++)
        ent_d[r][s] = (r < DEPTH-1) ? ent_q[(r < DEPTH-1) ? r+1 : r][s] : '0;
    end
    req_overflow = req_valid;
    for (int p = 0; p < NREQ; p++) begin
      for (int r = 0; r < DEPTH; r++) begin
        if (req_overflow[p] && cnt_d[r] < CNT_W'(WIDTH)) begin
          ent_d[r][cnt_d[r]] = {req_dst[p*NDST*REG_W +: NDST*REG_W],
                                req_dst_valid[p*NDST +: NDST],
                                ~req_squashed[p] & req_executed[p] & ~req_fault[p],
                                req_tag[p*TAG_W +: TAG_W]};
          cnt_d[r] = cnt_d[r] + 1'b1;
          req_overflow[p] = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int r = 0; r < DEPTH; r++)
      cnt_q[r] <= rst_n ? cnt_d[r] : '0;
  end

  always_ff @(posedge clk) begin
    for (int r = 0; r < DEPTH; r++)
      for (int s = 0; s < WIDTH; s++)
        ent_q[r][s] <= ent_d[r][s];
  end

  assign cmt_count = cnt_q[0];

  for (genvar s = 0; s < WIDTH; s++) begin : g_head
    assign cmt_valid[s] = CNT_W'(s) < cnt_q[0];
    assign cmt_tag[s*TAG_W +: TAG_W] = ent_q[0][s][TAG_W-1:0];
    assign cmt_wake[s] = cmt_valid[s] & ent_q[0][s][EL_B];
    for (genvar d = 0; d < NDST; d++) begin : g_dst
      assign sb_set_valid[s*NDST+d] = cmt_wake[s] & ent_q[0][s][DV_B+d];
      assign sb_set_reg[(s*NDST+d)*REG_W +: REG_W] = ent_q[0][s][DR_B+d*REG_W +: REG_W];
      a_r8_sb_gate: assert property (@(posedge clk) disable iff (!rst_n)
        sb_set_valid[s*NDST+d] |-> cmt_wake[s] && cmt_valid[s]);
    end
  end

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_count <= CNT_W'(WIDTH));

  a_r5_shift: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cnt_q[0] >= $past(cnt_q[1]));

  for (genvar p = 0; p < NREQ; p++) begin : g_port_chk
    a_r7_overflow_full: assert property (@(posedge clk) disable iff (!rst_n)
      req_overflow[p] |=> cmt_count == CNT_W'(WIDTH));
    a_r2_placed_visible: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid[p] && !req_overflow[p] |=> cmt_count != '0);
    a_r7_only_valid: assert property (@(posedge clk) disable iff (!rst_n)
      req_overflow[p] |-> req_valid[p]);
  end
endmodule

// File: tb/wb_slot_alloc_tb.sv
`timescale 1ns/1ps
module wb_slot_alloc_tb;
  localparam int W = 2, D = 4, N = 3, TW = 6, ND = 2, RW = 5;
  localparam int CW = $clog2(W+1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] req_valid = '0, req_squashed = '0, req_executed = '0, req_fault = '0;
  logic [N*TW-1:0] req_tag = '0;
  logic [N*ND-1:0] req_dst_valid = '0;
  logic [N*ND*RW-1:0] req_dst = '0;
  logic [N-1:0] req_overflow;
  logic [W-1:0] cmt_valid, cmt_wake;
  logic [W*TW-1:0] cmt_tag;
  logic [CW-1:0] cmt_count;
  logic [W*ND-1:0] sb_set_valid;
  logic [W*ND*RW-1:0] sb_set_reg;

  wb_slot_alloc #(.WIDTH(W), .DEPTH(D), .NREQ(N), .TAG_W(TW), .NDST(ND), .REG_W(RW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tag(req_tag),
    .req_squashed(req_squashed), .req_executed(req_executed), .req_fault(req_fault),
    .req_dst_valid(req_dst_valid), .req_dst(req_dst), .req_overflow(req_overflow),
    .cmt_valid(cmt_valid), .cmt_tag(cmt_tag), .cmt_count(cmt_count), .cmt_wake(cmt_wake),
    .sb_set_valid(sb_set_valid), .sb_set_reg(sb_set_reg));

  always #4 clk = ~clk;

  int nchk = 0, nerr = 0, novf = 0;
  bit done = 0;
  int mcnt [D];
  int mtag [D][W];
  bit mel [D][W];
  bit [ND-1:0] mdv [D][W];
  int mdr [D][W][ND];

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic bit elig(input int p);
    return !req_squashed[p] && req_executed[p] && !req_fault[p];
  endfunction

  task automatic set_req(input int p, input int tag, input bit sq, input bit ex, input bit f,
                         input bit [ND-1:0] dv, input int r0, input int r1);
    req_valid[p] = 1'b1;
    req_tag[p*TW +: TW] = TW'(tag);
    req_squashed[p] = sq; req_executed[p] = ex; req_fault[p] = f;
    req_dst_valid[p*ND +: ND] = dv;
    req_dst[p*ND*RW +: RW] = RW'(r0);
    req_dst[(p*ND+1)*RW +: RW] = RW'(r1);
  endtask

  task automatic clear_req();
    req_valid = '0;
  endtask

  task automatic check_head();
    chk(cmt_count == CW'(mcnt[0]), "R6 head count", cmt_count, mcnt[0]);
    for (int s = 0; s < W; s++) begin
      chk(cmt_valid[s] == (s < mcnt[0]), "R6 valid packing", cmt_valid[s], s < mcnt[0]);
      if (s < mcnt[0]) begin
        chk(cmt_tag[s*TW +: TW] == TW'(mtag[0][s]), "R5 head tag", cmt_tag[s*TW +: TW], mtag[0][s]);
        chk(cmt_wake[s] == mel[0][s], "R8 wake gate", cmt_wake[s], mel[0][s]);
        for (int d = 0; d < ND; d++) begin
          chk(sb_set_valid[s*ND+d] == (mel[0][s] && mdv[0][s][d]), "R8 sb strobe",
              sb_set_valid[s*ND+d], mel[0][s] && mdv[0][s][d]);
          if (mel[0][s] && mdv[0][s][d])
            chk(sb_set_reg[(s*ND+d)*RW +: RW] == RW'(mdr[0][s][d]), "R8 sb reg",
                sb_set_reg[(s*ND+d)*RW +: RW], mdr[0][s][d]);
        end
      end else begin
        chk(cmt_wake[s] == 1'b0, "R8 wake on empty slot", cmt_wake[s], 0);
      end
    end
  endtask

  task automatic tick();
    check_head();
    #1;
    for (int r = 0; r < D; r++) begin
      mcnt[r] = (r < D-1) ? mcnt[r+1] : 0;
      for (int s = 0; s < W; s++) if (r < D-1) begin
        mtag[r][s] = mtag[r+1][s]; mel[r][s] = mel[r+1][s]; mdv[r][s] = mdv[r+1][s];
        for (int d = 0; d < ND; d++) mdr[r][s][d] = mdr[r+1][s][d];
      end
    end
    for (int p = 0; p < N; p++) begin
      bit miss = req_valid[p];
      for (int r = 0; r < D; r++) if (miss && mcnt[r] < W) begin
        mtag[r][mcnt[r]] = req_tag[p*TW +: TW];
        mel[r][mcnt[r]] = elig(p);
        mdv[r][mcnt[r]] = req_dst_valid[p*ND +: ND];
        for (int d = 0; d < ND; d++) mdr[r][mcnt[r]][d] = req_dst[(p*ND+d)*RW +: RW];
        mcnt[r]++;
        miss = 0;
      end
      if (miss) novf++;
      chk(req_overflow[p] == miss, "R7 overflow flag", req_overflow[p], miss);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'd20240611);
    for (int r = 0; r < D; r++) mcnt[r] = 0;
    repeat (3) @(negedge clk);
    chk(cmt_count == 0 && cmt_valid == 0, "R1 reset head", cmt_count, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmt_count == 0 && cmt_valid == 0, "R1 after reset", cmt_count, 0);

    set_req(1, 5, 0, 1, 0, 2'b11, 3, 7); tick(); clear_req();
    chk(cmt_valid[0] && cmt_tag[TW-1:0] == 6'd5, "R2 single at slot 0", cmt_tag[TW-1:0], 5);
    chk(sb_set_valid == 4'b0011 && sb_set_reg[RW-1:0] == 5'd3, "R8 dst regs", sb_set_valid, 3);
    tick();

    set_req(2, 11, 0, 1, 0, 2'b01, 1, 0); set_req(0, 10, 0, 1, 0, 2'b01, 2, 0); tick(); clear_req();
    chk(cmt_tag[TW-1:0] == 6'd10 && cmt_tag[2*TW-1:TW] == 6'd11, "R3 port order", cmt_tag[TW-1:0], 10);
    tick();

    set_req(0, 20, 0, 1, 0, 2'b00, 0, 0); set_req(1, 21, 1, 1, 0, 2'b11, 4, 4);
    set_req(2, 22, 0, 1, 1, 2'b11, 6, 6); tick(); clear_req();
    chk(cmt_count == 2 && cmt_valid[1] && !cmt_wake[1], "R9 squashed forwarded", cmt_wake[1], 0);
    tick();
    chk(cmt_count == 1 && cmt_tag[TW-1:0] == 6'd22, "R4 spill to next row", cmt_tag[TW-1:0], 22);
    chk(!cmt_wake[0] && sb_set_valid == 0, "R9 faulted no wake", cmt_wake[0], 0);
    tick();

    set_req(0, 30, 0, 0, 0, 2'b11, 1, 1); tick(); clear_req();
    chk(cmt_valid[0] && !cmt_wake[0], "R9 unexecuted forwarded", cmt_wake[0], 0);
    tick();

    for (int i = 0; i < 12; i++) begin
      for (int p = 0; p < N; p++) set_req(p, (i*3+p) % 64, 0, 1, 0, 2'b10, p, i % 32);
      tick();
    end
    clear_req();
    chk(novf > 0, "R7 overflow reached", novf, 1);
    for (int i = 0; i < D+1; i++) tick();
    chk(cmt_count == 0, "R5 drained", cmt_count, 0);

    for (int i = 0; i < 3000; i++) begin
      for (int p = 0; p < N; p++) begin
        if ($urandom_range(99) < 55)
          set_req(p, $urandom_range(63), $urandom_range(3) == 0, $urandom_range(3) != 0,
                  $urandom_range(4) == 0, 2'($urandom_range(3)), $urandom_range(31), $urandom_range(31));
        else req_valid[p] = 1'b0;
      end
      tick();
    end
    clear_req();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule